// File: doc/BRIEF.md
# Non-Volatile Memory Read Controller with One-Word Prefetch

This block sits between a processor's instruction or data fetch port and a word-wide non-volatile memory array. Each array read takes either zero or one wait state, as the latency bit of a small control register selects. The block applies whatever value software writes. It does not judge whether that value suits the clock frequency.

When the prefetch-enable bit is set, the block keeps the address of the last word it returned to the requester. In cycles where no demand read is waiting and the array is not busy with a write, it reads the following word into a one-word buffer. A demand for the buffered word is answered in the next cycle with no array access. Any other demand discards the buffer and goes to the array. A demand that arrives while a speculative read is in flight abandons that read and starts its own array access in the same cycle.

The fetch port uses a valid/ready handshake. The requester holds `req_addr` stable until `req_ready` is seen. Each accepted request produces one single-cycle `rsp_valid` strobe with its data. The array is modelled as a synchronous-read memory: a word addressed in a cycle with `arr_en` high appears on `arr_rdata` in the next cycle.

Top module: `nvm_fetch_ctrl`

## Requirements
- R1: After reset the control register reads 5'b00111: bits [2:0] are lock flags at 1, bit 3 (latency) is 0 and bit 4 (prefetch enable) is 0. `rsp_valid` and `arr_en` are low.
- R2: With latency 0, a request that misses is accepted in a cycle that drives `arr_en` high with `arr_addr` equal to `req_addr`. Its `rsp_valid` comes two cycles after acceptance and carries the array word at that address.
- R3: With latency 1, a missing request's `rsp_valid` comes three cycles after acceptance and carries the array word.
- R4: A request whose address equals the valid buffered word is accepted with `arr_en` low, and its response comes in the next cycle.
- R5: A speculative array read targets the address after the last returned one. It is issued only in a cycle with `req_valid` low and `wr_busy` low.
- R6: A request arriving while a speculative read is in flight is accepted in that same cycle. The speculative read is dropped, and the request is served from the array at its own address with the correct data.
- R7: While `buf_dis` is high, prefetch enable (bit 4) reads 0 in the following cycle, even when a register write sets it in the same cycle.
- R8: While `wr_busy` is high, `req_ready` stays low and the buffered word is discarded. The next read of that address is a miss that returns the array's current content.
- R9: A register write that changes the latency bit discards the buffered word, so the next read of that address is a miss.
- R10: Bits [2:0] of the control register always read 1 and ignore writes. The latency bit takes any written value without a check.
- R11: Each accepted request yields exactly one single-cycle `rsp_valid`, in request order. No response appears without a request.
- R12: With prefetch enable at 0, `arr_en` is never high except in the cycles that serve an accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Control register write data |
| cfg_rdata | output | 5 | Control register contents |
| buf_dis | input | 1 | Buffer disable; clears prefetch enable |
| wr_busy | input | 1 | Array is being written by another agent |
| req_valid | input | 1 | Fetch request valid |
| req_addr | input | AW | Fetch word address |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Read data strobe, one cycle per request |
| rsp_data | output | DW | Read data |
| arr_en | output | 1 | Array read enable |
| arr_addr | output | AW | Array word address |
| arr_rdata | input | DW | Array read data, one cycle after the address |

## Verification
Assertions check every cycle that acceptance during `wr_busy` never happens and that hit and miss responses arrive after exactly one, two or three cycles for the latency in force. They also check that speculative reads launch only in idle cycles and only with prefetch enabled, that a miss drives the requested address to the array, and that `buf_dis` clears the enable bit. Only the bench's scenarios can show that returned data is correct after a write or a latency change. They also show that an aborted speculative read never leaks into a response, that the lock flags resist writes, and that the response stream stays one-to-one with accepted requests.

// File: rtl/nvm_fetch_pkg.sv
package nvm_fetch_pkg;

    localparam int CFG_W  = 5;
    localparam int LOCK_W = 3;

    // Control register layout, msb first: prefetch enable, latency, lock flags
    typedef struct packed {
        logic              pf_on;
        logic              slow;
        logic [LOCK_W-1:0] lock;
    } nvm_cfg_t;

    localparam nvm_cfg_t CFG_RST = '{pf_on: 1'b0, slow: 1'b0, lock: {LOCK_W{1'b1}}};

    typedef enum logic {
        ST_IDLE,
        ST_READ
    } rd_state_e;

    typedef enum logic {
        RK_DEMAND,
        RK_SPEC
    } rd_kind_e;

    // Merge a software write: lock flags are not writable here
    function automatic nvm_cfg_t cfg_apply(nvm_cfg_t cur, nvm_cfg_t wr);
        nvm_cfg_t r;
        r       = wr;
        r.lock  = cur.lock;
        return r;
    endfunction

endpackage

// File: rtl/nvm_cfg_reg.sv
module nvm_cfg_reg
    import nvm_fetch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             buf_dis,
    output nvm_cfg_t         cfg_q,
    output logic             lat_flush
);

    nvm_cfg_t cfg_n;

    always_comb begin
        cfg_n = cfg_q;
        if (cfg_we) begin
            cfg_n = cfg_apply(cfg_q, nvm_cfg_t'(cfg_wdata));
        end
        // hardware clear has priority over a software set
        if (buf_dis) begin
            cfg_n.pf_on = 1'b0;
        end
    end

    // any latency change invalidates speculative state
    assign lat_flush = (cfg_n.slow != cfg_q.slow);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_n;
        end
    end

endmodule

// File: rtl/nvm_pf_buffer.sv
module nvm_pf_buffer #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          consume,
    input  logic          fill,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data,
    input  logic [AW-1:0] look_addr,
    output logic          buf_v,
    output logic [AW-1:0] buf_addr,
    output logic [DW-1:0] buf_data,
    output logic          look_hit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_v    <= 1'b0;
            buf_addr <= '0;
            buf_data <= '0;
        end else if (clr || consume) begin
            buf_v    <= 1'b0;
        end else if (fill) begin
            buf_v    <= 1'b1;
            buf_addr <= fill_addr;
            buf_data <= fill_data;
        end
    end

    assign look_hit = buf_v && (buf_addr == look_addr);

endmodule

// File: rtl/nvm_read_seq.sv
module nvm_read_seq
    import nvm_fetch_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          arr_en,
    output logic [AW-1:0] arr_addr,
    input  logic [DW-1:0] arr_rdata,
    input  logic          wr_busy,
    input  logic          lat_sel,
    input  logic          pf_allow,
    input  logic          lat_flush,
    input  logic          buf_v,
    input  logic [AW-1:0] buf_addr,
    input  logic [DW-1:0] buf_data,
    input  logic          look_hit,
    output logic          buf_clr,
    output logic          buf_consume,
    output logic          buf_fill,
    output logic [AW-1:0] buf_fill_addr,
    output logic [DW-1:0] buf_fill_data,
    output logic          pf_launch
);

    rd_state_e     st_q,   st_n;
    rd_kind_e      kind_q, kind_n;
    logic          wait_q, wait_n;
    logic [AW-1:0] addr_q, addr_n;
    logic [AW-1:0] seed_q, seed_n;
    logic          seed_v_q, seed_v_n;
    logic          rsp_v_n;
    logic [DW-1:0] rsp_d_n;

    logic [AW-1:0] seed_next;
    logic          spec_kill;
    logic          may_serve;
    logic          spec_wanted;

    assign seed_next   = seed_q + AW'(1);
    assign spec_kill   = lat_flush || wr_busy || !pf_allow;
    assign may_serve   = req_valid && !wr_busy &&
                         ((st_q == ST_IDLE) || (kind_q == RK_SPEC));
    assign spec_wanted = seed_v_q && !(buf_v && (buf_addr == seed_next));

    assign buf_fill_addr = addr_q;
    assign buf_fill_data = arr_rdata;

    always_comb begin
        st_n        = st_q;
        kind_n      = kind_q;
        wait_n      = wait_q;
        addr_n      = addr_q;
        seed_n      = seed_q;
        seed_v_n    = seed_v_q;
        rsp_v_n     = 1'b0;
        rsp_d_n     = rsp_data;
        req_ready   = 1'b0;
        arr_en      = 1'b0;
        arr_addr    = addr_q;
        buf_clr     = spec_kill;
        buf_consume = 1'b0;
        buf_fill    = 1'b0;
        pf_launch   = 1'b0;

        if (may_serve) begin
            req_ready = 1'b1;
            if ((st_q == ST_IDLE) && look_hit && pf_allow) begin
                // served from the buffer, no array access
                buf_consume = 1'b1;
                rsp_v_n     = 1'b1;
                rsp_d_n     = buf_data;
                seed_n      = req_addr;
                seed_v_n    = 1'b1;
            end else begin
                // miss, or abort of an in-flight speculative read
                buf_clr  = 1'b1;
                arr_en   = 1'b1;
                arr_addr = req_addr;
                st_n     = ST_READ;
                kind_n   = RK_DEMAND;
                wait_n   = lat_sel;
                addr_n   = req_addr;
            end
        end else if (st_q == ST_READ) begin
            if ((kind_q == RK_SPEC) && spec_kill) begin
                st_n = ST_IDLE;
            end else begin
                arr_en = 1'b1;
                if (wait_q) begin
                    wait_n = 1'b0;
                end else begin
                    st_n = ST_IDLE;
                    if (kind_q == RK_DEMAND) begin
                        rsp_v_n  = 1'b1;
                        rsp_d_n  = arr_rdata;
                        seed_n   = addr_q;
                        seed_v_n = 1'b1;
                    end else begin
                        buf_fill = 1'b1;
                    end
                end
            end
        end else if (!req_valid && !spec_kill && spec_wanted) begin
            pf_launch = 1'b1;
            buf_clr   = 1'b1;
            arr_en    = 1'b1;
            arr_addr  = seed_next;
            st_n      = ST_READ;
            kind_n    = RK_SPEC;
            wait_n    = lat_sel;
            addr_n    = seed_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            kind_q    <= RK_DEMAND;
            wait_q    <= 1'b0;
            addr_q    <= '0;
            seed_q    <= '0;
            seed_v_q  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            st_q      <= st_n;
            kind_q    <= kind_n;
            wait_q    <= wait_n;
            addr_q    <= addr_n;
            seed_q    <= seed_n;
            seed_v_q  <= seed_v_n;
            rsp_valid <= rsp_v_n;
            rsp_data  <= rsp_d_n;
        end
    end

endmodule

// File: rtl/nvm_fetch_ctrl.sv
module nvm_fetch_ctrl
    import nvm_fetch_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             buf_dis,
    input  logic             wr_busy,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic             arr_en,
    output logic [AW-1:0]    arr_addr,
    input  logic [DW-1:0]    arr_rdata
);

    nvm_cfg_t      cfg_q;
    logic          lat_flush;
    logic          buf_v, look_hit;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_data;
    logic          buf_clr, buf_consume, buf_fill;
    logic [AW-1:0] buf_fill_addr;
    logic [DW-1:0] buf_fill_data;
    logic          pf_launch;

    assign cfg_rdata = cfg_q;

    nvm_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .buf_dis   (buf_dis),
        .cfg_q     (cfg_q),
        .lat_flush (lat_flush)
    );

    nvm_pf_buffer #(.AW(AW), .DW(DW)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clr       (buf_clr),
        .consume   (buf_consume),
        .fill      (buf_fill),
        .fill_addr (buf_fill_addr),
        .fill_data (buf_fill_data),
        .look_addr (req_addr),
        .buf_v     (buf_v),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data),
        .look_hit  (look_hit)
    );

    nvm_read_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_ready     (req_ready),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data),
        .arr_en        (arr_en),
        .arr_addr      (arr_addr),
        .arr_rdata     (arr_rdata),
        .wr_busy       (wr_busy),
        .lat_sel       (cfg_q.slow),
        .pf_allow      (cfg_q.pf_on),
        .lat_flush     (lat_flush),
        .buf_v         (buf_v),
        .buf_addr      (buf_addr),
        .buf_data      (buf_data),
        .look_hit      (look_hit),
        .buf_clr       (buf_clr),
        .buf_consume   (buf_consume),
        .buf_fill      (buf_fill),
        .buf_fill_addr (buf_fill_addr),
        .buf_fill_data (buf_fill_data),
        .pf_launch     (pf_launch)
    );

endmodule

// File: rtl/nvm_fetch_chk.sv
module nvm_fetch_chk
    import nvm_fetch_pkg::*;
#(
    parameter int AW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             buf_dis,
    input logic             wr_busy,
    input logic             req_valid,
    input logic [AW-1:0]    req_addr,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             arr_en,
    input logic [AW-1:0]    arr_addr,
    input logic             pf_launch
);

    nvm_cfg_t c;
    assign c = nvm_cfg_t'(cfg_rdata);

    // R8: no acceptance while the array is being written
    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        wr_busy |-> !req_ready);

    // R4: a hit does not touch the array and answers next cycle
    a_r4_hit_next: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !arr_en) |=> rsp_valid);

    // R2: zero wait state miss answers two cycles later
    a_r2_miss_lat0: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && arr_en && !c.slow) |=> !rsp_valid ##1 rsp_valid);

    // R3: one wait state miss answers three cycles later
    a_r3_miss_lat1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && arr_en && c.slow) |=> !rsp_valid ##1 !rsp_valid ##1 rsp_valid);

    // R6: an accepted miss (including an abort) drives its own address
    a_r6_own_addr: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && arr_en) |-> (arr_addr == req_addr));

    // R5: speculation only in idle cycles
    a_r5_pf_idle: assert property (@(posedge clk) disable iff (rst)
        pf_launch |-> (!req_valid && !wr_busy && arr_en));

    // R12: speculation only when enabled
    a_r12_pf_gated: assert property (@(posedge clk) disable iff (rst)
        pf_launch |-> c.pf_on);

    // R7: buffer disable clears the enable bit
    a_r7_bufdis_clears: assert property (@(posedge clk) disable iff (rst)
        buf_dis |=> !c.pf_on);

endmodule

bind nvm_fetch_ctrl nvm_fetch_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .buf_dis   (buf_dis),
    .wr_busy   (wr_busy),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .arr_en    (arr_en),
    .arr_addr  (arr_addr),
    .pf_launch (pf_launch)
);

// File: tb/nvm_fetch_ctrl_tb_top.sv
module nvm_fetch_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int DW         = 32;
    localparam int NWORDS     = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_wdata = '0;
    logic [4:0]    cfg_rdata;
    logic          buf_dis = 1'b0;
    logic          wr_busy = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          arr_en;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    bit cur_lat = 1'b0;

    logic [DW-1:0] mem [NWORDS];
    int            q_due [$];
    logic [DW-1:0] q_dat [$];
    string         q_tag [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // register-file array model, synchronous read
    always @(posedge clk) begin
        if (arr_en) arr_rdata <= mem[arr_addr];
    end

    nvm_fetch_ctrl #(.AW(AW), .DW(DW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .buf_dis   (buf_dis),
        .wr_busy   (wr_busy),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .arr_en    (arr_en),
        .arr_addr  (arr_addr),
        .arr_rdata (arr_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // per-cycle response comparison against the expectation queue
    always @(negedge clk) begin
        if (!rst) begin
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                chk(rsp_valid === 1'b1, {q_tag[0], " R11"}, "rsp_valid at due cycle",
                    DW'(rsp_valid), DW'(1));
                chk(rsp_data === q_dat[0], q_tag[0], "rsp_data", rsp_data, q_dat[0]);
                void'(q_due.pop_front());
                void'(q_dat.pop_front());
                void'(q_tag.pop_front());
            end else if (rsp_valid) begin
                chk(1'b0, "R11", "response without due request", DW'(rsp_valid), DW'(0));
            end
        end
    end

    // called at a falling edge; returns at a falling edge
    task automatic rd(input int a, input bit hit, input int idle, input string tag);
        int d;
        req_valid = 1'b1;
        req_addr  = AW'(a);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        if (hit) chk(arr_en == 1'b0, tag, "hit must not read array", DW'(arr_en), DW'(0));
        else     chk(arr_en == 1'b1 && arr_addr == AW'(a), tag, "miss array address",
                     DW'(arr_addr), DW'(a));
        d = hit ? 1 : (cur_lat ? 3 : 2);
        q_due.push_back(cyc + d);
        q_dat.push_back(mem[a]);
        q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (idle) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [4:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        cur_lat   = v[3];
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic idle_noarr(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            #1;
            chk(arr_en == 1'b0, tag, "array read with prefetch off", DW'(arr_en), DW'(0));
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < NWORDS; i++) mem[i] = 32'hA500_0000 ^ DW'(i * 32'h0101_0101);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(cfg_rdata == 5'b00111, "R1", "control reset value", DW'(cfg_rdata), DW'(5'b00111));
        chk(rsp_valid == 1'b0 && arr_en == 1'b0, "R1", "idle outputs after reset",
            DW'({rsp_valid, arr_en}), DW'(0));
        @(negedge clk);

        // R2 misses with prefetch off; R12 no speculation
        rd(5, 1'b0, 0, "R2");
        rd(9, 1'b0, 1, "R2");
        idle_noarr(4, "R12");

        // prefetch on, latency 0
        cfg_write(5'b10000);
        rd(10, 1'b0, 0, "R2");
        @(negedge clk);
        #1;
        chk(arr_en == 1'b1 && arr_addr == AW'(11), "R5", "speculative address",
            DW'(arr_addr), DW'(11));
        @(negedge clk);
        @(negedge clk);
        rd(11, 1'b1, 3, "R4");
        rd(12, 1'b1, 1, "R4");
        // speculative read of 13 is in flight: demand elsewhere
        rd(40, 1'b0, 3, "R6");
        rd(41, 1'b1, 4, "R6 R4");

        // latency change drops the buffered 42
        cfg_write(5'b11000);
        rd(42, 1'b0, 5, "R9 R3");
        rd(43, 1'b1, 6, "R4 R3");

        // write activity: blocked and buffer dropped
        wr_busy   = 1'b1;
        mem[44]   = 32'hDEAD_0044;
        req_valid = 1'b1;
        req_addr  = AW'(44);
        #1;
        chk(req_ready == 1'b0, "R8", "ready during write", DW'(req_ready), DW'(0));
        @(negedge clk);
        #1;
        chk(req_ready == 1'b0, "R8", "ready during write", DW'(req_ready), DW'(0));
        @(negedge clk);
        wr_busy = 1'b0;
        rd(44, 1'b0, 3, "R8");

        // R7, R10: buffer disable beats a set; lock flags hold
        buf_dis = 1'b1;
        cfg_write(5'b11111);
        buf_dis = 1'b0;
        #1;
        chk(cfg_rdata == 5'b01111, "R7 R10", "enable cleared, lock kept",
            DW'(cfg_rdata), DW'(5'b01111));
        @(negedge clk);
        idle_noarr(4, "R12");
        cfg_write(5'b00000);
        #1;
        chk(cfg_rdata == 5'b00111, "R10", "lock flags ignore write", DW'(cfg_rdata), DW'(5'b00111));
        @(negedge clk);

        // R11: back-to-back misses
        rd(20, 1'b0, 0, "R2 R11");
        rd(21, 1'b0, 0, "R2 R11");
        rd(22, 1'b0, 2, "R2 R11");
        idle_noarr(3, "R12");
        repeat (3) @(negedge clk);
        chk(q_due.size() == 0, "R11", "responses outstanding", DW'(q_due.size()), DW'(0));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11 act=%0d exp=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule